// File: doc/BRIEF.md
# Asynchronous SRAM-Style Bus Master

This block sits between an internal requester and an external asynchronous memory-style bus. The requester presents a single read or write: a write flag, a region number, a word address and a write word. The block runs one fixed-length bus cycle for it. The bus has separate address and 16-bit data lines, one active-low chip select per region, an active-low output enable and an active-low write enable. When the cycle ends, the block returns a one-cycle acknowledge. For a read, the captured data word comes back together with that acknowledge.

Every bus cycle has two parts. The first is an address-setup phase, in which the address and the chosen chip select are valid and both strobes stay high. The second is a data phase, in which the read or write strobe is held low. Both lengths are counted in system clocks and come from a single timing set that reads and writes share. The timing set is loaded through a small configuration write port. Address hold and bus turnaround add no extra cycles. After reset the setup length is 14 clocks and the data length is 16 clocks.

Top module: `sram_bus_master`

## Requirements
- R1: While reset is low and in the first cycle after it, every chip select, output enable and write enable is high, `ack` is low and `req_ready` is high.
- R2: After reset, with no configuration write, an access has an address-setup phase of DEF_SETUP clocks and a data phase of DEF_DATA clocks (14 and 16 by default).
- R3: After an access is accepted, only the chip select of the requested region goes low, for exactly setup+data clocks. During the first setup clocks both strobes are high. During the last data clocks, output enable (read) or write enable (write) is low and the other strobe stays high.
- R4: A programmed setup or data count of 0 behaves as a count of 1.
- R5: During a write's whole data phase, the data bus carries the requested write word. While a chip select is low, the address lines hold the requested address.
- R6: For a read, `ack_rdata` shows the data-bus value sampled on the last clock of the data phase, in the cycle where `ack` is high.
- R7: `ack` is high for exactly one clock per access. That clock is the first one after the chip select returns high.
- R8: `req_ready` is high only when no access is in progress. A request presented while an access is in progress is ignored and causes no bus cycle.
- R9: A configuration write while an access is in progress is ignored. A configuration write while idle takes effect for the next access, including one requested in the same clock.
- R10: A new request can be accepted in the clock where `ack` is high. Its chip select then goes low on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | RG_W | Region number selecting the chip select |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write word |
| req_ready | output | 1 | Block idle; request is accepted on this clock |
| ack | output | 1 | One-clock completion pulse |
| ack_rdata | output | DATA_W | Read data, valid with ack for reads |
| cfg_wr | input | 1 | Load the timing set |
| cfg_setup | input | CNT_W | Address-setup length in clocks (0 means 1) |
| cfg_data | input | CNT_W | Data-phase length in clocks (0 means 1) |
| bus_addr | output | ADDR_W | External address lines |
| bus_cs_n | output | N_REGION | Active-low chip select per region |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable |
| bus_data | inout | DATA_W | External data bus, driven only during a write data phase |

## Verification
The bench builds the block with a 4-bit address, four regions and a 5-bit count width, and keeps the default lengths of 14 and 16. The narrow address lets a 64-word bench memory model cover every region and word. The narrow count makes the largest count of 31 cheap to reach, next to counts of 0 and 1. The defaults are measured once straight after reset, and random short timings then exercise the phase boundaries many times.

// File: rtl/sram_bus_master.sv
module sram_bus_master #(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int N_REGION  = 4,
  parameter int CNT_W     = 8,
  parameter int DEF_SETUP = 14,
  parameter int DEF_DATA  = 16,
  localparam int RG_W     = (N_REGION > 1) ? $clog2(N_REGION) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [RG_W-1:0]   req_region,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              ack,
  output logic [DATA_W-1:0] ack_rdata,
  input  logic              cfg_wr,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [N_REGION-1:0] bus_cs_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  inout  wire  [DATA_W-1:0] bus_data
);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_DATA} phase_t;

  phase_t            st;
  logic [CNT_W-1:0]  cnt, setup_q, data_q, nxt_setup;
  logic [ADDR_W-1:0] addr_q;
  logic [RG_W-1:0]   rg_q;
  logic              wr_q, ack_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  wire idle      = (st == ST_IDLE);
  wire in_data   = (st == ST_DATA);
  wire cfg_take  = idle && cfg_wr;
  wire last_tick = (cnt == '0);

  assign nxt_setup = cfg_take ? cfg_setup : setup_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      setup_q <= CNT_W'(DEF_SETUP);
      data_q  <= CNT_W'(DEF_DATA);
      addr_q  <= '0;
      rg_q    <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cfg_wr) begin
            setup_q <= cfg_setup;
            data_q  <= cfg_data;
          end
          if (req_valid) begin
            st      <= ST_SETUP;
            cnt     <= (nxt_setup == '0) ? '0 : nxt_setup - 1'b1;
            addr_q  <= req_addr;
            rg_q    <= req_region;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
          end
        end
        ST_SETUP: begin
          if (last_tick) begin
            st  <= ST_DATA;
            cnt <= (data_q == '0) ? '0 : data_q - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_DATA: begin
          if (last_tick) begin
            st    <= ST_IDLE;
            ack_q <= 1'b1;
            if (!wr_q) rdata_q <= bus_data;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_REGION; gi++) begin : g_cs
      assign bus_cs_n[gi] = !(!idle && (rg_q == RG_W'(gi)));
    end
  endgenerate

  assign bus_addr  = addr_q;
  assign bus_oe_n  = !(in_data && !wr_q);
  assign bus_we_n  = !(in_data && wr_q);
  assign bus_data  = (in_data && wr_q) ? wdata_q : {DATA_W{1'bz}};
  assign req_ready = idle;
  assign ack       = ack_q;
  assign ack_rdata = rdata_q;

endmodule

// File: rtl/sram_bus_master_chk.sv
module sram_bus_master_chk #(
  parameter int N_REGION = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_REGION-1:0] bus_cs_n,
  input logic                bus_oe_n,
  input logic                bus_we_n,
  input logic                ack,
  input logic                req_ready
);

  a_r3_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  a_r3_strobe_has_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> (bus_cs_n != {N_REGION{1'b1}}));

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));

  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r7_ack_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_n) |-> ack);

  a_r7_ack_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we_n) |-> ack);

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n == {N_REGION{1'b1}}));

endmodule

bind sram_bus_master sram_bus_master_chk #(.N_REGION(N_REGION)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
  .bus_we_n(bus_we_n), .ack(ack), .req_ready(req_ready)
);

// File: tb/sram_bus_master_tb_top.sv
module sram_bus_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NR = 4;
  localparam int CW = 5;
  localparam int DEPTH = NR * (1 << AW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_region = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, ack;
  logic [15:0] ack_rdata;
  logic cfg_wr = 1'b0;
  logic [CW-1:0] cfg_setup = '0, cfg_data = '0;
  logic [AW-1:0] bus_addr;
  logic [NR-1:0] bus_cs_n;
  logic bus_oe_n, bus_we_n;
  wire  [15:0] bus_data;

  int checks = 0, errors = 0, cycles = 0;
  int cur_s = 14, cur_d = 16;
  logic [15:0] dev_mem [DEPTH];
  logic [15:0] exp_mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bus_master #(.ADDR_W(AW), .N_REGION(NR), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_region(req_region), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .ack(ack), .ack_rdata(ack_rdata), .cfg_wr(cfg_wr),
    .cfg_setup(cfg_setup), .cfg_data(cfg_data), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_data(bus_data)
  );

  function automatic int cs_region(input logic [NR-1:0] cs);
    for (int i = 0; i < NR; i++) if (!cs[i]) return i;
    return 0;
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [15:0] seed_word(input int i);
    return 16'(i * 16'h1357) ^ 16'hA5A5;
  endfunction

  wire [5:0] dev_idx = 6'({cs_region(bus_cs_n), bus_addr});
  assign bus_data = (!bus_oe_n) ? dev_mem[dev_idx] : 16'hzzzz;

  always @(posedge clk) begin
    if (!bus_we_n) dev_mem[dev_idx] <= bus_data;
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles %0d expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int s, input int d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_setup = CW'(s); cfg_data = CW'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
    cur_s = s; cur_d = d;
  endtask

  // poke: raise a request and a config write mid-access; chain: issue a read in the ack cycle
  task automatic access(input logic wr, input int rg, input int a, input logic [15:0] wd,
                        input bit poke, input bit chain);
    int es, ed, n, cs_cnt, stb_cnt, bad_order, bad_wd, bad_addr, bad_other;
    logic [15:0] exp_rd;
    es = eff(cur_s); ed = eff(cur_d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_region = 2'(rg);
    req_addr = AW'(a); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; cs_cnt = 0; stb_cnt = 0; bad_order = 0; bad_wd = 0; bad_addr = 0; bad_other = 0;
    while (!ack && n < 400) begin
      logic sl, ol;
      if (!bus_cs_n[rg]) cs_cnt++;
      for (int i = 0; i < NR; i++) if (i != rg && !bus_cs_n[i]) bad_other++;
      sl = wr ? !bus_we_n : !bus_oe_n;
      ol = wr ? !bus_oe_n : !bus_we_n;
      if (ol) bad_order++;
      if (sl) stb_cnt++;
      if (sl && cs_cnt <= es) bad_order++;
      if (!sl && !bus_cs_n[rg] && cs_cnt > es) bad_order++;
      if (!bus_cs_n[rg] && bus_addr != AW'(a)) bad_addr++;
      if (wr && sl && bus_data != wd) bad_wd++;
      if (!bus_cs_n[rg] && req_ready) bad_order++;
      if (poke && n == 2) begin
        req_valid = 1'b1; req_write = ~wr; req_addr = AW'(a + 1);
        cfg_wr = 1'b1; cfg_setup = '0; cfg_data = '0;
      end
      if (poke && n == 3) begin
        req_valid = 1'b0; cfg_wr = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    chk("R3 chip-select length", cs_cnt == es + ed, cs_cnt, es + ed);
    chk("R3 strobe length", stb_cnt == ed, stb_cnt, ed);
    chk("R3 phase order and strobe choice", bad_order == 0, bad_order, 0);
    chk("R3 other regions deselected", bad_other == 0, bad_other, 0);
    chk("R5 address held", bad_addr == 0, bad_addr, 0);
    chk("R7 ack with chip select high", ack && bus_cs_n == '1, int'(bus_cs_n), 'hf);
    chk("R10 ready in ack cycle", req_ready == 1'b1, req_ready, 1);
    if (wr) begin
      chk("R5 write data on bus", bad_wd == 0, bad_wd, 0);
      exp_mem[rg*16 + a] = wd;
    end else begin
      exp_rd = exp_mem[rg*16 + a];
      chk("R6 read data", ack_rdata == exp_rd, ack_rdata, exp_rd);
    end
    if (chain) begin
      req_valid = 1'b1; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 chip select low right after ack", bus_cs_n[rg] == 1'b0, bus_cs_n[rg], 0);
      n = 0;
      while (!ack && n < 400) begin @(negedge clk); n++; end
      chk("R10 chained read data", ack_rdata == exp_mem[rg*16 + a], ack_rdata, exp_mem[rg*16 + a]);
    end
    @(negedge clk);
    chk("R7 ack one clock", ack == 1'b0, ack, 0);
    if (poke) begin
      n = 0;
      for (int k = 0; k < 6; k++) begin
        if (ack || bus_cs_n != '1) n++;
        @(negedge clk);
      end
      chk("R8 busy request ignored", n == 0, n, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      dev_mem[i] = seed_word(i);
      exp_mem[i] = seed_word(i);
    end
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk("R1 reset chip selects", bus_cs_n == '1, int'(bus_cs_n), 'hf);
    chk("R1 reset strobes", bus_oe_n && bus_we_n, {bus_oe_n, bus_we_n}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", req_ready && !ack && bus_cs_n == '1, {req_ready, ack}, 2);

    // R2 default timing, read then write
    access(1'b0, 1, 3, 16'h0, 1'b0, 1'b0);
    access(1'b1, 2, 7, 16'hBEEF, 1'b0, 1'b0);
    // R4 zero counts behave as one
    set_cfg(0, 0);
    access(1'b1, 0, 5, 16'h1234, 1'b0, 1'b0);
    access(1'b0, 0, 5, 16'h0, 1'b0, 1'b0);
    // largest count
    set_cfg(31, 1);
    access(1'b0, 3, 15, 16'h0, 1'b0, 1'b0);
    // R8 and R9: busy request and busy config write ignored
    set_cfg(3, 2);
    access(1'b1, 1, 9, 16'hCAFE, 1'b1, 1'b0);
    access(1'b0, 1, 9, 16'h0, 1'b0, 1'b0);
    // R9 config write in the same clock as a request
    @(negedge clk);
    cfg_wr = 1'b1; cfg_setup = 5'd2; cfg_data = 5'd4;
    cur_s = 2; cur_d = 4;
    access(1'b0, 2, 7, 16'h0, 1'b0, 1'b0);
    cfg_wr = 1'b0;
    // R10 back-to-back write then read
    access(1'b1, 3, 4, 16'h5A5A, 1'b0, 1'b1);

    for (int t = 0; t < 40; t++) begin
      if ($urandom_range(0, 2) == 0) set_cfg($urandom_range(0, 6), $urandom_range(0, 6));
      access(1'($urandom_range(0, 1)), $urandom_range(0, NR - 1), $urandom_range(0, 15),
             16'($urandom), 1'b0, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule